// File: doc/BRIEF.md
# Picture-Bus Page Translator

This block sits between a picture processor's 14-bit video bus and the memories behind it. It chooses the memory that serves each fetch, and the location inside that memory. The lower half of the space, 0x0000 to 0x1FFF, holds eight 1 KB pattern slots. Each slot is served from a 1 KB page of character ROM, and eight 8-bit bank registers supply the page numbers. A 2-bit layout field in an 8-bit mode word says which register feeds which slot. The upper half, 0x2000 to 0x3FFF, holds four 1 KB nametable quadrants, repeated once. Those quadrants come either from character-ROM pages or from the console's own 2 KB nametable RAM, and another mode bit makes that choice.

The bank registers and the mode word are plain inputs. Whatever loads them is outside this block. The block decodes one address per clock. Its result is registered, so each output reflects the inputs that were present at the previous rising edge. A ROM fetch produces a ROM byte address, made of the page number followed by the low ten address bits. A nametable RAM fetch produces a single page-select bit, which drives the RAM's upper address line.

Top module: `ppu_bank_xlate`

## Requirements
- R1: While rst_n is low, and after its release until the first decode, rom_fetch, ram_fetch, ram_page and rom_addr are all zero.
- R2: Outputs change only at a rising clock edge. After each edge they show the decode of the inputs present at that edge, and inputs changed between edges leave them as they are.
- R3: With mode bits [1:0] = 0, pattern slot s (address bits [12:10], bit 13 clear) takes its page from register s. Register n is bank_regs[8n+7:8n].
- R4: With mode bits [1:0] = 1, slots 2k and 2k+1 both take their page from register k, for k = 0 to 3.
- R5: With mode bits [1:0] = 2 or 3, slots 0 to 3 take their pages from registers 0 to 3. Slots 4 and 5 form a pair on register 4, and slots 6 and 7 form a pair on register 5.
- R6: When mode bit 5 is set, the paired slots of R4 and R5 replace page bit 0: the even slot gets 0 and the odd slot gets 1. When bit 5 is clear, the register value is used whole.
- R7: A pattern fetch sets rom_fetch. rom_addr is then {page[CHR_PAGE_W-1:0], addr[9:0]}, so page numbers wrap modulo the ROM page count.
- R8: With mode bit 4 set, nametable quadrant q (address bits [11:10]) is a ROM fetch. The masked code k = mode & 0x2F sets page bit 0 by a fixed rule. For k = 0x20 or 0x27 the quadrants take r6, r6, r7, r7 with bit 0 = 0,1,0,1. For k = 0x23 or 0x24 they take r6, r7, r6, r7 with bit 0 = 0,0,1,1. For k = 0x28 or 0x2F they take r6, r6, r7, r7 with bit 0 = 0. For k = 0x2B or 0x2C they take r6, r7, r6, r7 with bit 0 = 1.
- R9: With mode bit 4 set and any other masked code, mode bits [2:0] choose the quadrant registers, used unaltered. Values 0, 6 and 7 give r6, r6, r7, r7. Values 1 and 5 give r4, r5, r6, r7. Values 2, 3 and 4 give r6, r7, r6, r7.
- R10: With mode bit 4 clear, a nametable fetch sets ram_fetch and clears rom_fetch and rom_addr. Every fetch sets exactly one of rom_fetch and ram_fetch. The fixed codes of R8 give RAM pages of 0,1,0,1 (0x20/0x27), 0,0,1,1 (0x23/0x24), all 0 (0x28/0x2F) and all 1 (0x2B/0x2C).
- R11: With mode bit 4 clear and any other code, ram_page is bit 0 of the register that R9 names for that quadrant. ram_page is 0 during any ROM fetch.
- R12: A nametable address 0x3000 to 0x3FFF decodes exactly as the same address with bit 12 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_regs | input | 64 | Eight 8-bit bank registers, register n at bits [8n+7:8n] |
| mode_reg | input | 8 | Banking mode word |
| ppu_addr | input | 14 | Video bus address |
| rom_fetch | output | 1 | Registered: fetch goes to character ROM |
| ram_fetch | output | 1 | Registered: fetch goes to nametable RAM |
| ram_page | output | 1 | Registered: nametable RAM page select |
| rom_addr | output | CHR_PAGE_W+10 | Registered: character ROM byte address |

## Verification
Directed sweeps visit every slot under each of the three pattern layouts. Each of these sweeps uses register values with distinct odd and even pages, so a slot wired to the wrong register, or a pairing bit that is missing, shows up at once. Every fixed mirroring code and every value of the low three mode bits is applied to all four quadrants, with ROM nametables and with RAM nametables. Here r6 is even and r7 is odd, which separates a forced page bit from an inherited one. Paired 0x2xxx and 0x3xxx addresses confirm the mirror. Constrained-random mode words, registers and addresses then mix in the unused mode bits. A mid-cycle input change shows that the output register holds.

// File: rtl/ppu_bank_pkg.sv
package ppu_bank_pkg;

    typedef logic [7:0] page_t;

    // What happens to bit 0 of a page number
    typedef enum logic [1:0] {
        LOW_KEEP = 2'd0,
        LOW_CLR  = 2'd1,
        LOW_SET  = 2'd2
    } low_op_e;

    // Pattern layout field, mode bits [1:0]
    typedef enum logic [1:0] {
        PL_DIRECT  = 2'd0,
        PL_PAIRS   = 2'd1,
        PL_SPLIT_A = 2'd2,
        PL_SPLIT_B = 2'd3
    } pat_layout_e;

    function automatic page_t apply_low(page_t r, low_op_e op);
        case (op)
            LOW_CLR: return {r[7:1], 1'b0};
            LOW_SET: return {r[7:1], 1'b1};
            default: return r;
        endcase
    endfunction

endpackage

// File: rtl/ppu_pattern_slots.sv
module ppu_pattern_slots
    import ppu_bank_pkg::*;
(
    input  page_t       regs      [8],
    input  logic [1:0]  layout,
    input  logic        pair_on,
    output page_t       slot_page [8]
);

    for (genvar s = 0; s < 8; s++) begin : g_slot
        localparam int      PAIR_SRC  = s / 2;
        localparam int      SPLIT_SRC = (s < 4) ? s : ((s < 6) ? 4 : 5);
        localparam bit      SPLIT_PR  = (s >= 4);
        localparam low_op_e SIDE_OP   = (s % 2 == 1) ? LOW_SET : LOW_CLR;
        localparam low_op_e SPLIT_OP  = SPLIT_PR ? SIDE_OP : LOW_KEEP;

        always_comb begin
            case (pat_layout_e'(layout))
                PL_DIRECT: slot_page[s] = regs[s];
                PL_PAIRS:  slot_page[s] = apply_low(regs[PAIR_SRC],
                                                    pair_on ? SIDE_OP : LOW_KEEP);
                default:   slot_page[s] = apply_low(regs[SPLIT_SRC],
                                                    pair_on ? SPLIT_OP : LOW_KEEP);
            endcase
        end
    end

endmodule

// File: rtl/ppu_nt_quads.sv
module ppu_nt_quads
    import ppu_bank_pkg::*;
(
    input  page_t       nt_regs   [4],   // registers 4..7
    input  logic [4:0]  code,            // {mode[5], mode[3:0]}
    output page_t       quad_page [4]
);

    logic [1:0] src [4];
    low_op_e    op  [4];

    always_comb begin
        src = '{2'd2, 2'd2, 2'd3, 2'd3};
        op  = '{LOW_KEEP, LOW_KEEP, LOW_KEEP, LOW_KEEP};
        case (code)
            5'b1_0000, 5'b1_0111: begin
                src = '{2'd2, 2'd2, 2'd3, 2'd3};
                op  = '{LOW_CLR, LOW_SET, LOW_CLR, LOW_SET};
            end
            5'b1_0011, 5'b1_0100: begin
                src = '{2'd2, 2'd3, 2'd2, 2'd3};
                op  = '{LOW_CLR, LOW_CLR, LOW_SET, LOW_SET};
            end
            5'b1_1000, 5'b1_1111: begin
                src = '{2'd2, 2'd2, 2'd3, 2'd3};
                op  = '{LOW_CLR, LOW_CLR, LOW_CLR, LOW_CLR};
            end
            5'b1_1011, 5'b1_1100: begin
                src = '{2'd2, 2'd3, 2'd2, 2'd3};
                op  = '{LOW_SET, LOW_SET, LOW_SET, LOW_SET};
            end
            default: begin
                case (code[2:0])
                    3'd1, 3'd5:       src = '{2'd0, 2'd1, 2'd2, 2'd3};
                    3'd2, 3'd3, 3'd4: src = '{2'd2, 2'd3, 2'd2, 2'd3};
                    default:          src = '{2'd2, 2'd2, 2'd3, 2'd3};
                endcase
            end
        endcase
    end

    for (genvar q = 0; q < 4; q++) begin : g_quad
        always_comb quad_page[q] = apply_low(nt_regs[src[q]], op[q]);
    end

endmodule

// File: rtl/ppu_bank_xlate.sv
module ppu_bank_xlate
    import ppu_bank_pkg::*;
#(
    parameter int CHR_PAGE_W = 8      // log2 of ROM page count, at most 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [63:0]            bank_regs,
    input  logic [7:0]             mode_reg,
    input  logic [13:0]            ppu_addr,
    output logic                   rom_fetch,
    output logic                   ram_fetch,
    output logic                   ram_page,
    output logic [CHR_PAGE_W+9:0]  rom_addr
);

    localparam int ROM_AW = CHR_PAGE_W + 10;

    page_t regs      [8];
    page_t nt_regs   [4];
    page_t slot_page [8];
    page_t quad_page [4];

    for (genvar g = 0; g < 8; g++) begin : g_unpack
        assign regs[g] = bank_regs[8*g +: 8];
    end
    for (genvar g = 0; g < 4; g++) begin : g_nt
        assign nt_regs[g] = regs[g+4];
    end

    logic unused_mode_hi;
    assign unused_mode_hi = ^mode_reg[7:6];

    ppu_pattern_slots i_slots (
        .regs      (regs),
        .layout    (mode_reg[1:0]),
        .pair_on   (mode_reg[5]),
        .slot_page (slot_page)
    );

    ppu_nt_quads i_quads (
        .nt_regs   (nt_regs),
        .code      ({mode_reg[5], mode_reg[3:0]}),
        .quad_page (quad_page)
    );

    // Decode stage
    logic              is_pattern;
    logic              nt_in_rom;
    page_t             sel_page;
    logic              rom_fetch_n;
    logic              ram_fetch_n;
    logic              ram_page_n;
    logic [ROM_AW-1:0] rom_addr_n;

    always_comb begin
        is_pattern  = ~ppu_addr[13];
        nt_in_rom   = mode_reg[4];
        sel_page    = is_pattern ? slot_page[ppu_addr[12:10]]
                                 : quad_page[ppu_addr[11:10]];
        rom_fetch_n = is_pattern | nt_in_rom;
        ram_fetch_n = ~rom_fetch_n;
        ram_page_n  = ram_fetch_n & sel_page[0];
        rom_addr_n  = rom_fetch_n ? {sel_page[CHR_PAGE_W-1:0], ppu_addr[9:0]}
                                  : '0;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_fetch <= 1'b0;
            ram_fetch <= 1'b0;
            ram_page  <= 1'b0;
            rom_addr  <= '0;
        end else begin
            rom_fetch <= rom_fetch_n;
            ram_fetch <= ram_fetch_n;
            ram_page  <= ram_page_n;
            rom_addr  <= rom_addr_n;
        end
    end

    // Checks on the registered stage
    logic primed;
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        $countones({rom_fetch, ram_fetch}) == 1);                          // R10

    AST_PATTERN_ROM: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        !$past(ppu_addr[13]) |-> rom_fetch);                               // R7

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        rom_fetch |-> rom_addr[9:0] == $past(ppu_addr[9:0]));               // R7

    AST_PAIR_SIDE: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ($past(mode_reg[5]) && $past(mode_reg[1:0]) == 2'd1 && !$past(ppu_addr[13]))
        |-> rom_addr[10] == $past(ppu_addr[10]));                          // R6

    AST_RAM_PATH: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ($past(ppu_addr[13]) && !$past(mode_reg[4])) |-> (ram_fetch && rom_addr == '0)); // R10

    AST_PAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        rom_fetch |-> !ram_page);                                          // R11

endmodule

// File: tb/test_ppu_bank_xlate.sv
module test_ppu_bank_xlate;

    localparam int PW = 8;
    localparam int AW = PW + 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   bank_regs = '0;
    logic [7:0]    mode_reg = '0;
    logic [13:0]   ppu_addr = '0;
    logic          rom_fetch;
    logic          ram_fetch;
    logic          ram_page;
    logic [AW-1:0] rom_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ppu_bank_xlate #(.CHR_PAGE_W(PW)) i_ppu_bank_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_regs (bank_regs),
        .mode_reg  (mode_reg),
        .ppu_addr  (ppu_addr),
        .rom_fetch (rom_fetch),
        .ram_fetch (ram_fetch),
        .ram_page  (ram_page),
        .rom_addr  (rom_addr)
    );

    function automatic logic [7:0] reg_of(logic [63:0] br, int i);
        return br[8*i +: 8];
    endfunction

    function automatic logic [7:0] model_page(logic [7:0] m, logic [63:0] br, logic [13:0] a);
        int src;
        bit paired;
        bit forced;
        bit lowv;
        logic [7:0] p;
        logic [7:0] key;
        int q;
        int slot;
        forced = 0;
        lowv = 0;
        if (!a[13]) begin
            slot = int'(a[12:10]);
            if (m[1:0] == 2'd0)      begin src = slot;     paired = 0; end
            else if (m[1:0] == 2'd1) begin src = slot / 2; paired = 1; end
            else if (slot < 4)       begin src = slot;     paired = 0; end
            else                     begin src = (slot < 6) ? 4 : 5; paired = 1; end
            p = reg_of(br, src);
            if (paired && m[5]) p = {p[7:1], slot[0]};
            return p;
        end
        q = int'(a[11:10]);
        key = m & 8'h2F;
        if (key == 8'h20 || key == 8'h27)      begin src = q[1] ? 7 : 6; lowv = q[0]; forced = 1; end
        else if (key == 8'h23 || key == 8'h24) begin src = q[0] ? 7 : 6; lowv = q[1]; forced = 1; end
        else if (key == 8'h28 || key == 8'h2F) begin src = q[1] ? 7 : 6; lowv = 0;    forced = 1; end
        else if (key == 8'h2B || key == 8'h2C) begin src = q[0] ? 7 : 6; lowv = 1;    forced = 1; end
        else if (m[2:0] == 3'd1 || m[2:0] == 3'd5)                    src = 4 + q;
        else if (m[2:0] == 3'd2 || m[2:0] == 3'd3 || m[2:0] == 3'd4)  src = q[0] ? 7 : 6;
        else                                                          src = q[1] ? 7 : 6;
        p = reg_of(br, src);
        if (forced) p = {p[7:1], lowv};
        return p;
    endfunction

    function automatic logic [AW+2:0] model_out(logic [7:0] m, logic [63:0] br, logic [13:0] a);
        logic [7:0] p;
        bit rom;
        p = model_page(m, br, a);
        rom = !a[13] || m[4];
        return {rom, !rom, (!rom) & p[0], rom ? {p[PW-1:0], a[9:0]} : {AW{1'b0}}};
    endfunction

    function automatic string req_for(logic [7:0] m, logic [13:0] a);
        logic [7:0] key;
        bit fixed;
        key = m & 8'h2F;
        fixed = (key == 8'h20 || key == 8'h27 || key == 8'h23 || key == 8'h24 ||
                 key == 8'h28 || key == 8'h2F || key == 8'h2B || key == 8'h2C);
        if (!a[13]) begin
            if (m[1:0] == 2'd0) return "R3/R7";
            if (m[5])           return (m[1:0] == 2'd1) ? "R4/R6" : "R5/R6";
            return (m[1:0] == 2'd1) ? "R4" : "R5";
        end
        if (m[4]) return fixed ? "R8" : "R9";
        return fixed ? "R10" : "R11";
    endfunction

    task automatic compare(string req, logic [AW+2:0] exp_v);
        logic [AW+2:0] act;
        act = {rom_fetch, ram_fetch, ram_page, rom_addr};
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (mode=%h addr=%h)",
                     req, act, exp_v, mode_reg, ppu_addr);
        end
    endtask

    task automatic drive_check(logic [7:0] m, logic [63:0] br, logic [13:0] a, string req);
        @(negedge clk);
        mode_reg  = m;
        bank_regs = br;
        ppu_addr  = a;
        @(posedge clk);
        #2;
        compare(req, model_out(m, br, a));
    endtask

    // r0..r7 with distinct pages, r6 even, r7 odd
    localparam logic [63:0] DREGS = {8'h7B, 8'h36, 8'h55, 8'h4A, 8'h33, 8'h2C, 8'h11, 8'h0E};

    initial begin
        logic [63:0] br;
        logic [7:0]  m;
        logic [13:0] a;
        logic [AW+2:0] held;
        void'($urandom(32'd2024));

        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        compare("R1", '0);
        @(negedge clk);
        mode_reg = 8'h10; ppu_addr = 14'h2123; bank_regs = DREGS;
        @(posedge clk);
        #2;
        compare("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3, R4, R5, R6: every slot under every layout, pairing on and off
        for (int lay = 0; lay < 4; lay++) begin
            for (int pr = 0; pr < 2; pr++) begin
                for (int s = 0; s < 8; s++) begin
                    m = {2'b00, pr[0], 3'b000, lay[1:0]};
                    a = {1'b0, s[2:0], 10'h2A5};
                    drive_check(m, DREGS, a, req_for(m, a));
                end
            end
        end

        // R8, R10: fixed codes, ROM and RAM nametables
        foreach (m_codes[i]) begin
            for (int src = 0; src < 2; src++) begin
                for (int q = 0; q < 4; q++) begin
                    m = m_codes[i] | (src[0] ? 8'h10 : 8'h00);
                    a = {2'b10, q[1:0], 10'h1C3};
                    drive_check(m, DREGS, a, req_for(m, a));
                end
            end
        end

        // R9, R11: low three mode bits with non-fixed codes
        for (int v = 0; v < 8; v++) begin
            for (int src = 0; src < 2; src++) begin
                for (int q = 0; q < 4; q++) begin
                    m = {4'b0000, src[0], v[2:0]};
                    a = {2'b10, q[1:0], 10'h3FF};
                    drive_check(m, DREGS, a, req_for(m, a));
                end
            end
        end

        // R12: upper mirror decodes like the lower nametable copy
        for (int i = 0; i < 40; i++) begin
            br = {$urandom, $urandom};
            m  = 8'($urandom);
            a  = {2'b11, 12'($urandom)};
            @(negedge clk);
            mode_reg = m; bank_regs = br; ppu_addr = a;
            @(posedge clk);
            #2;
            compare("R12", model_out(m, br, {2'b10, a[11:0]}));
        end

        // R2: mid-cycle input change does not reach the outputs
        drive_check(8'h21, DREGS, 14'h0C00, "R2");
        held = {rom_fetch, ram_fetch, ram_page, rom_addr};
        @(negedge clk);
        mode_reg = 8'h0B; ppu_addr = 14'h2800;
        #3;
        compare("R2", held);
        @(posedge clk);
        #2;
        compare("R2", model_out(8'h0B, DREGS, 14'h2800));

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            br = {$urandom, $urandom};
            case ($urandom % 3)
                0:       m = m_codes[$urandom % 8] | (($urandom % 2) ? 8'h10 : 8'h00) | 8'($urandom & 32'hC0);
                default: m = 8'($urandom);
            endcase
            a = 14'($urandom);
            drive_check(m, br, a, req_for(m, a));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    logic [7:0] m_codes [8] = '{8'h20, 8'h27, 8'h23, 8'h24, 8'h28, 8'h2F, 8'h2B, 8'h2C};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule